// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Register Slave

This block lets an external bus master reach a small file of 16-bit registers over an 8-bit parallel bus. The same eight wires carry the register address and the data bytes. The master uses four active-low or active-high controls: a chip select, a write strobe, a read strobe and an address latch enable. All controls are asynchronous to the block. They pass through multi-flop synchronizers into a fast system clock domain. Edges are detected there, and the bus bytes are sampled in the same clock cycle as the edge that uses them.

An access starts with an address phase: the master places a register index on the bus and drops the latch enable. Two data strobes follow. The first moves the most significant byte and the second moves the least significant byte, so the internal byte slot steps from the MSB position to the LSB position between them. On writes, the first byte waits in a staging register and the whole word is committed at the end of the second strobe. On reads, the whole word is captured when the first byte is read, and the second byte comes from that capture. The block never drives the shared bus itself. It presents the outgoing byte together with an output enable for an external tristate pad, and raises that enable only during a read strobe.

Top module: `madbus_slave`

## Requirements
- R1: After reset, bus_ad_oe is low and every register entry reads as 0x0000.
- R2: A falling edge of bus_ale while bus_cs_n is low latches bus_ad_in as the register index. A falling edge of bus_ale while bus_cs_n is high leaves the latched index unchanged.
- R3: Two write strobes after an address phase store {first byte, second byte} into the indexed entry, with the first byte as bits 15:8. The entry keeps its old value until the second write strobe ends, so a lone first byte followed by a new address phase leaves it unchanged.
- R4: The first read strobe after an address phase presents bits 15:8 of the indexed entry on bus_ad_out, and the second read strobe presents bits 7:0.
- R5: bus_ad_oe goes high within 3 clock cycles of bus_rd_n falling while chip select is low. It goes low within 3 clock cycles of bus_rd_n rising.
- R6: Indexes 16 to 255 read as 0x0000 and ignore writes. A write to such an index does not alter the entry it would reach if the upper index bits were dropped.
- R7: A falling edge of bus_ale restarts byte sequencing, so the next strobe transfers a most significant byte even if only one byte of the previous access was moved.
- R8: Write and read strobes given while bus_cs_n is high have no effect: no entry changes and bus_ad_oe stays low.
- R9: While chip select stays low, further strobe pairs without a new address phase access the same register again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Chip select, active low, asynchronous |
| bus_wr_n | input | 1 | Write strobe, active low; data captured on its rising edge |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_ale | input | 1 | Address latch enable; index captured on its falling edge |
| bus_ad_in | input | 8 | Shared address/data bus as seen from the pad |
| bus_ad_out | output | 8 | Byte to drive onto the shared bus during a read |
| bus_ad_oe | output | 1 | Output enable for the external tristate driver |

## Verification
The assertions assume that each strobe level lasts at least a few clock cycles. This lets every edge pass through the synchronizers and be seen exactly once. They also assume that the bus byte is still valid when the synchronized edge arrives, and that the latch enable does not fall within the same cycle as a read edge. The stimulus holds every strobe level for five or six clock cycles. It keeps the address or write byte on the bus for six cycles after the closing edge, and it separates address phases from data strobes by several idle cycles. Under those conditions, the output-enable, sequencer-restart and out-of-range properties apply at every clock edge.

// File: rtl/madbus_pkg.sv
package madbus_pkg;

    localparam int BUS_W  = 8;
    localparam int WORD_W = 2 * BUS_W;

    // Complete registered state of the bus sequencer
    typedef struct packed {
        logic [BUS_W-1:0]  base;      // latched register index
        logic              lsb_slot;  // 0: next strobe moves MSB, 1: moves LSB
        logic [BUS_W-1:0]  stage;     // staged write MSB
        logic [WORD_W-1:0] snap;      // read snapshot taken on MSB read
        logic [BUS_W-1:0]  dout;      // byte presented to the pad
        logic              oe;        // pad output enable
        logic              wr_prev;   // previous synchronized strobe levels
        logic              rd_prev;
        logic              ale_prev;
    } seq_state_t;

    localparam seq_state_t SEQ_RESET = '{
        base: '0, lsb_slot: 1'b0, stage: '0, snap: '0, dout: '0,
        oe: 1'b0, wr_prev: 1'b1, rd_prev: 1'b1, ale_prev: 1'b0
    };

endpackage

// File: rtl/madbus_sync.sv
module madbus_sync #(
    parameter int             WIDTH  = 4,
    parameter int             STAGES = 2,       // must be at least 2
    parameter logic [WIDTH-1:0] INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{INIT}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/madbus_regfile.sv
module madbus_regfile #(
    parameter int ENTRIES = 16,
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0][DATA_W-1:0] mem_d, mem_q;
    logic w_hit, r_hit;

    // Full-width compare so indexes above the file never alias
    assign w_hit = {1'b0, waddr} < (ADDR_W+1)'(ENTRIES);
    assign r_hit = {1'b0, raddr} < (ADDR_W+1)'(ENTRIES);

    always_comb begin
        mem_d = mem_q;
        if (we && w_hit) mem_d[waddr[IDX_W-1:0]] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign rdata = r_hit ? mem_q[raddr[IDX_W-1:0]] : '0;

endmodule

// File: rtl/madbus_slave.sv
module madbus_slave
    import madbus_pkg::*;
#(
    parameter int REG_COUNT   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_cs_n,
    input  logic             bus_wr_n,
    input  logic             bus_rd_n,
    input  logic             bus_ale,
    input  logic [BUS_W-1:0] bus_ad_in,
    output logic [BUS_W-1:0] bus_ad_out,
    output logic             bus_ad_oe
);

    seq_state_t        q_q, q_d;
    logic              cs_s_n, wr_s, rd_s, ale_s;
    logic              wr_rise, rd_fall, rd_rise, ale_fall, cs_act;
    logic              commit;
    logic [WORD_W-1:0] rd_word;

    // Strobes idle high, latch enable idle low
    madbus_sync #(
        .WIDTH (4),
        .STAGES(SYNC_STAGES),
        .INIT  (4'b1110)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({bus_cs_n, bus_wr_n, bus_rd_n, bus_ale}),
        .dout ({cs_s_n, wr_s, rd_s, ale_s})
    );

    assign cs_act   = !cs_s_n;
    assign wr_rise  = wr_s && !q_q.wr_prev;
    assign rd_fall  = !rd_s && q_q.rd_prev;
    assign rd_rise  = rd_s && !q_q.rd_prev;
    assign ale_fall = !ale_s && q_q.ale_prev;

    madbus_regfile #(
        .ENTRIES(REG_COUNT),
        .DATA_W (WORD_W),
        .ADDR_W (BUS_W)
    ) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (commit),
        .waddr(q_q.base),
        .wdata({q_q.stage, bus_ad_in}),
        .raddr(q_q.base),
        .rdata(rd_word)
    );

    always_comb begin
        q_d          = q_q;
        commit       = 1'b0;
        q_d.wr_prev  = wr_s;
        q_d.rd_prev  = rd_s;
        q_d.ale_prev = ale_s;

        // Pad is released as soon as the read strobe or chip select ends
        if (!cs_act || rd_s) q_d.oe = 1'b0;

        if (cs_act) begin
            if (ale_fall) begin
                q_d.base     = bus_ad_in;
                q_d.lsb_slot = 1'b0;
            end else if (wr_rise) begin
                if (!q_q.lsb_slot) q_d.stage = bus_ad_in;
                else               commit    = 1'b1;
                q_d.lsb_slot = !q_q.lsb_slot;
            end else if (rd_fall) begin
                q_d.oe = 1'b1;
                if (!q_q.lsb_slot) begin
                    q_d.snap = rd_word;
                    q_d.dout = rd_word[WORD_W-1:BUS_W];
                end else begin
                    q_d.dout = q_q.snap[BUS_W-1:0];
                end
            end else if (rd_rise) begin
                q_d.lsb_slot = !q_q.lsb_slot;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= SEQ_RESET;
        else        q_q <= q_d;
    end

    assign bus_ad_out = q_q.dout;
    assign bus_ad_oe  = q_q.oe;

endmodule

// File: rtl/madbus_checker.sv
module madbus_checker #(
    parameter int REG_COUNT = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_s_n,
    input logic       rd_s,
    input logic       ale_s,
    input logic       ale_prev,
    input logic       lsb_slot,
    input logic       commit,
    input logic [7:0] base,
    input logic [7:0] dout,
    input logic       oe
);

    always @(posedge clk) begin
        if (!rst_n) assert_reset_quiet_R1: assert (!oe && !commit);
    end

    assert_oe_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && rd_s) |=> !oe);

    assert_oe_needs_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s_n |=> !oe);

    assert_ale_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale_s && ale_prev && !cs_s_n) |=> !lsb_slot);

    assert_commit_in_lsb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> lsb_slot);

    assert_commit_ends_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !lsb_slot);

    assert_out_of_range_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(oe) && (int'(base) >= REG_COUNT)) |-> (dout == 8'h00));

endmodule

bind madbus_slave madbus_checker #(.REG_COUNT(REG_COUNT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_s_n  (cs_s_n),
    .rd_s    (rd_s),
    .ale_s   (ale_s),
    .ale_prev(q_q.ale_prev),
    .lsb_slot(q_q.lsb_slot),
    .commit  (commit),
    .base    (q_q.base),
    .dout    (q_q.dout),
    .oe      (q_q.oe)
);

// File: tb/sim_madbus_slave.sv
`timescale 1ns/1ps
module sim_madbus_slave;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, ale = 1'b0;
    logic [7:0] ad_in = 8'h00;
    logic [7:0] ad_out;
    logic       ad_oe;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [15:0] mdl [16];

    always #2 clk = ~clk;   // 250 MHz

    madbus_slave u0 (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_wr_n(wr_n),
        .bus_rd_n(rd_n), .bus_ale(ale), .bus_ad_in(ad_in),
        .bus_ad_out(ad_out), .bus_ad_oe(ad_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] expect_word(input logic [7:0] a);
        return (a < 8'd16) ? mdl[a[3:0]] : 16'h0000;
    endfunction

    task automatic bus_addr(input logic [7:0] a);
        ad_in = a; ale = 1'b1; tick(5);
        ale = 1'b0; tick(6);
    endtask

    task automatic bus_wr(input logic [7:0] b);
        ad_in = b; wr_n = 1'b0; tick(5);
        wr_n = 1'b1; tick(6);
    endtask

    task automatic bus_rd(input logic [7:0] exp, input string req);
        rd_n = 1'b0; tick(6);
        check("R5", "oe during read", int'(ad_oe), 1);
        check(req, "read byte", int'(ad_out), int'(exp));
        rd_n = 1'b1; tick(6);
        check("R5", "oe after read", int'(ad_oe), 0);
    endtask

    task automatic write_word(input logic [7:0] a, input logic [15:0] v);
        bus_addr(a); bus_wr(v[15:8]); bus_wr(v[7:0]);
        if (a < 8'd16) mdl[a[3:0]] = v;
    endtask

    task automatic read_word(input logic [7:0] a, input string req);
        logic [15:0] e;
        e = expect_word(a);
        bus_addr(a); bus_rd(e[15:8], req); bus_rd(e[7:0], req);
    endtask

    task automatic t_reset_R1;
        check("R1", "oe at reset", int'(ad_oe), 0);
        for (int i = 0; i < 16; i += 5) read_word(8'(i), "R1");
    endtask

    task automatic t_roundtrip_R3_R4;
        write_word(8'h03, 16'hA5C3);
        read_word(8'h03, "R4");
        for (int i = 0; i < 16; i++)
            write_word(8'(i), 16'(i * 16'h1111) ^ 16'h0F5A);
        for (int i = 15; i >= 0; i--) read_word(8'(i), "R3");
    endtask

    task automatic t_msb_staging_R3;
        write_word(8'h07, 16'h1234);
        bus_addr(8'h07); bus_wr(8'hFF);        // lone MSB
        read_word(8'h07, "R3");                // must still hold 0x1234
    endtask

    task automatic t_ale_restart_R7;
        logic [15:0] e;
        e = expect_word(8'h07);
        bus_addr(8'h07); bus_rd(e[15:8], "R7");
        bus_addr(8'h07); bus_rd(e[15:8], "R7"); bus_rd(e[7:0], "R7");
    endtask

    task automatic t_cs_gate_R2_R8;
        logic [15:0] e;
        e = expect_word(8'h03);
        bus_addr(8'h03);
        cs_n = 1'b1; tick(6);
        bus_addr(8'h09);                        // ignored index
        bus_wr(8'hDE); bus_wr(8'hAD);           // ignored write
        rd_n = 1'b0; tick(6);
        check("R8", "oe with cs high", int'(ad_oe), 0);
        rd_n = 1'b1; tick(6);
        cs_n = 1'b0; tick(6);
        bus_rd(e[15:8], "R2"); bus_rd(e[7:0], "R2");
        read_word(8'h03, "R8");
    endtask

    task automatic t_same_reg_R9;
        bus_addr(8'h0A);
        bus_wr(8'h11); bus_wr(8'h11);
        bus_wr(8'h2B); bus_wr(8'h2C);
        mdl[10] = 16'h2B2C;
        bus_rd(8'h2B, "R9"); bus_rd(8'h2C, "R9");
        bus_rd(8'h2B, "R9"); bus_rd(8'h2C, "R9");
    endtask

    task automatic t_out_of_range_R6;
        write_word(8'h15, 16'hBEEF);
        read_word(8'h15, "R6");
        read_word(8'h05, "R6");
        write_word(8'hFF, 16'h4321);
        read_word(8'hFF, "R6");
        read_word(8'h0F, "R6");
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mdl[i] = 16'h0000;
        tick(4);
        rst_n = 1'b1;
        tick(4);
        cs_n = 1'b0;
        tick(4);
        t_reset_R1();
        t_roundtrip_R3_R4();
        t_msb_staging_R3();
        t_ale_restart_R7();
        t_cs_gate_R2_R8();
        t_same_reg_R9();
        t_out_of_range_R6();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule